// File: doc/BRIEF.md
# Single-Line Non-Maskable Interrupt Controller

This block watches one external non-maskable interrupt line and turns it into a processor interrupt. The raw line first passes through a synchronizer. A detector then matches the synchronized level against a two-bit trigger mode. The mode picks an active-low level, a falling edge, an active-high level or a rising edge. A match sets a pending flag. Software clears that flag by writing a one to it. A separate enable flag decides whether a pending event reaches the interrupt output.

Software reaches three registers through a plain single-cycle read/write port: control, pending and enable. The control register always sits at offset 0x00. A build parameter chooses where pending and enable sit, from three fixed layouts. Reset leaves the controller set to active-low level detection, with the interrupt masked and nothing pending.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset, reads of control, pending and enable return 0 and `irq_out` is 0.
- R2: A write to offset 0x00 stores `reg_wdata[1:0]` as the trigger mode. A read of 0x00 returns the mode in bits [1:0]. Every other bit of that register reads 0, and writes cannot change those bits.
- R3: Mode 0 (active-low level): pending sets while the synchronized line is 0.
- R4: Mode 1 (falling edge): pending sets on a 1-to-0 transition of the synchronized line.
- R5: Mode 2 (active-high level): pending sets while the synchronized line is 1.
- R6: Mode 3 (rising edge): pending sets on a 0-to-1 transition of the synchronized line.
- R7: Pending reads back in bit 0 of the pending register. Once set, it holds until a write with bit 0 = 1 arrives at that register. A write with bit 0 = 0 leaves it unchanged.
- R8: In a level mode, an acknowledge made while the line is still active leaves pending at 1.
- R9: Bit 0 of the enable register reads back as written. `irq_out` is 1 exactly when both pending and enable are 1.
- R10: Layout 0 places pending at 0x04 and enable at 0x08. Layout 1 places pending at 0x04 and enable at 0x34. Layout 2 places enable at 0x04 and pending at 0x08. Any other offset reads 0, and writes to it change nothing.
- R11: The input passes through two flops. Suppose `nmi_in` changes between clock edges. The resulting pending bit is then visible after the third rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_in | input | 1 | Raw external interrupt line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The main instance uses layout 0 with a 32-bit data path and 8-bit offsets. The bench runs all four trigger modes through the same script, so each mode gets its own assert, hold, acknowledge and mask checks and its own two-flop latency check. Two extra instances, built with layouts 1 and 2, share the same stimulus. With them, the bench checks the moved enable and pending offsets and confirms that offsets unmapped in one layout read as zero.

// File: rtl/nmi_ctrl_pkg.sv
package nmi_ctrl_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

  localparam int unsigned CTRL_OFF = 0;

  // Offset of the pending register for a given layout
  function automatic int unsigned pend_off(input int unsigned layout);
    case (layout)
      2:       return 8;
      default: return 4;
    endcase
  endfunction

  // Offset of the enable register for a given layout
  function automatic int unsigned en_off(input int unsigned layout);
    case (layout)
      1:       return 52;
      2:       return 4;
      default: return 8;
    endcase
  endfunction

  // Trigger match on current and previous synchronized samples
  function automatic logic trig_match(input trig_e mode, input logic cur, input logic prv);
    case (mode)
      TRIG_LVL_LO:    return ~cur;
      TRIG_EDGE_FALL: return prv & ~cur;
      TRIG_LVL_HI:    return cur;
      default:        return cur & ~prv;
    endcase
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nmi_trig_detect.sv
module nmi_trig_detect
  import nmi_ctrl_pkg::*;
#(
  parameter bit IDLE_VAL = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_s,
  input  trig_e mode,
  output logic  evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_VAL;
    else        prev_q <= line_s;
  end

  assign evt = trig_match(mode, line_s, prev_q);
endmodule

// File: rtl/nmi_reg_bank.sv
module nmi_reg_bank
  import nmi_ctrl_pkg::*;
#(
  parameter int unsigned LAYOUT = 0,
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wlow,
  input  logic              evt,
  output trig_e             mode,
  output logic              pend_q,
  output logic              en_q,
  output logic              ack_hit,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(pend_off(LAYOUT));
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(en_off(LAYOUT));

  logic sel_ctrl, sel_pend, sel_en;
  assign sel_ctrl = (addr == A_CTRL);
  assign sel_pend = (addr == A_PEND);
  assign sel_en   = (addr == A_EN);

  assign ack_hit = we & sel_pend & wlow[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= TRIG_LVL_LO;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (we && sel_ctrl) mode <= trig_e'(wlow);
      if (we && sel_en)   en_q <= wlow[0];
      pend_q <= evt | (pend_q & ~ack_hit);
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl)      rdata[1:0] = mode;
    else if (sel_pend) rdata[0]   = pend_q;
    else if (sel_en)   rdata[0]   = en_q;
  end
endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_ctrl_pkg::*;
#(
  parameter int unsigned LAYOUT      = 0,
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  logic  line_s;
  logic  det_evt;
  logic  ack_hit;
  logic  pend_q;
  logic  en_q;
  trig_e mode;

  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(nmi_in), .q(line_s)
  );

  nmi_trig_detect #(.IDLE_VAL(1'b1)) u_det (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .mode(mode), .evt(det_evt)
  );

  nmi_reg_bank #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wlow(reg_wdata[1:0]), .evt(det_evt), .mode(mode),
    .pend_q(pend_q), .en_q(en_q), .ack_hit(ack_hit), .rdata(reg_rdata)
  );

  assign irq_out = pend_q & en_q;
endmodule

// File: rtl/nmi_line_ctrl_chk.sv
module nmi_line_ctrl_chk
  import nmi_ctrl_pkg::*;
#(
  parameter int unsigned LAYOUT = 0,
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_out,
  input logic              evt,
  input logic              ack,
  input logic              pend_q,
  input logic              en_q
);
  logic mapped;
  assign mapped = (reg_addr == ADDR_W'(CTRL_OFF)) ||
                  (reg_addr == ADDR_W'(pend_off(LAYOUT))) ||
                  (reg_addr == ADDR_W'(en_off(LAYOUT)));

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> pend_q); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> en_q); // R9
  AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend_q); // R8
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack) |=> pend_q); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt) |=> !pend_q); // R7
  AST_PEND_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(evt)); // R11
  AST_CTRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(CTRL_OFF)) |-> (reg_rdata[DATA_W-1:2] == '0)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (reg_rdata == '0)); // R10
endmodule

bind nmi_line_ctrl nmi_line_ctrl_chk #(
  .LAYOUT(LAYOUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .irq_out(irq_out), .evt(det_evt), .ack(ack_hit), .pend_q(pend_q), .en_q(en_q)
);

// File: tb/nmi_line_ctrl_test.sv
module nmi_line_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_in = 1'b1;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] rdata_a, rdata_b, rdata_c;
  logic irq_a, irq_b, irq_c;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_line_ctrl #(.LAYOUT(0)) uut (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .irq_out(irq_a));
  nmi_line_ctrl #(.LAYOUT(1)) uut_b (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .irq_out(irq_b));
  nmi_line_ctrl #(.LAYOUT(2)) uut_c (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_c), .irq_out(irq_c));

  localparam logic [AW-1:0] CTRL = 8'h00, PEND = 8'h04, EN = 8'h08;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    reg_addr = a;
    #1;
    check(rdata_a == exp, req, rdata_a, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic idle_lvl, act_lvl, is_lvl;
    string rq;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R1: reset state
    rd_chk(CTRL, 0, "R1 ctrl");
    rd_chk(PEND, 0, "R1 pend");
    rd_chk(EN, 0, "R1 en");
    check(irq_a == 1'b0, "R1 irq", {31'b0, irq_a}, 0);
    // R10: unmapped offset ignored
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 0, "R10 unmapped read");
    rd_chk(CTRL, 0, "R10 ctrl untouched");
    rd_chk(EN, 0, "R10 en untouched");
    // R2: only mode bits stored
    wr(CTRL, 32'hFFFF_FFFF);
    rd_chk(CTRL, 32'h3, "R2 mode bits only");
    wr(CTRL, 32'hA5A5_A5A4);
    rd_chk(CTRL, 32'h0, "R2 upper bits ignored");

    for (int m = 0; m < 4; m++) begin
      is_lvl   = (m % 2 == 0);
      idle_lvl = (m < 2) ? 1'b1 : 1'b0;
      act_lvl  = ~idle_lvl;
      rq = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
      @(negedge clk); nmi_in = idle_lvl;
      wr(CTRL, m);
      idle(5);
      wr(PEND, 1);
      rd_chk(PEND, 0, {rq, " clear before event"});
      wr(EN, 1);
      rd_chk(EN, 1, "R9 enable readback");
      nmi_in = act_lvl;
      repeat (2) @(posedge clk); #1;
      rd_chk(PEND, 0, {"R11 not yet after two edges ", rq});
      @(posedge clk); #1;
      rd_chk(PEND, 1, {rq, " event sets pending"});
      check(irq_a == 1'b1, "R9 irq asserted", {31'b0, irq_a}, 1);
      idle(3);
      wr(PEND, 0);
      rd_chk(PEND, 1, "R7 write zero no effect");
      wr(PEND, 1);
      if (is_lvl) rd_chk(PEND, 1, "R8 level reasserts while active");
      else        rd_chk(PEND, 0, "R7 edge ack clears");
      @(negedge clk); nmi_in = idle_lvl;
      idle(6);
      if (is_lvl) rd_chk(PEND, 1, "R7 level pending held after release");
      else        rd_chk(PEND, 0, {rq, " opposite edge ignored"});
      wr(PEND, 1);
      rd_chk(PEND, 0, "R7 ack at idle clears");
      // set again, then mask
      @(negedge clk); nmi_in = act_lvl;
      idle(5);
      wr(EN, 0);
      rd_chk(PEND, 1, {rq, " second event"});
      check(irq_a == 1'b0, "R9 masked irq low", {31'b0, irq_a}, 0);
      rd_chk(EN, 0, "R9 enable cleared");
      @(negedge clk); nmi_in = idle_lvl;
      idle(5);
      wr(PEND, 1);
    end

    // R10: alternate layouts
    wr(CTRL, 0);
    @(negedge clk); nmi_in = 1'b1;
    idle(5);
    wr(8'h04, 1);
    wr(8'h08, 1);
    wr(8'h34, 1);
    reg_addr = 8'h34; #1;
    check(rdata_b == 1, "R10 layout1 enable at 0x34", rdata_b, 1);
    check(rdata_a == 0, "R10 layout0 0x34 unmapped", rdata_a, 0);
    reg_addr = 8'h04; #1;
    check(rdata_c == 1, "R10 layout2 enable at 0x04", rdata_c, 1);
    reg_addr = 8'h08; #1;
    check(rdata_c == 0, "R10 layout2 pending clear", rdata_c, 0);
    @(negedge clk); nmi_in = 1'b0;
    idle(5);
    reg_addr = 8'h08; #1;
    check(rdata_c == 1, "R10 layout2 pending at 0x08", rdata_c, 1);
    check(irq_c == 1'b1, "R10 layout2 irq", {31'b0, irq_c}, 1);
    reg_addr = 8'h04; #1;
    check(rdata_b == 1, "R10 layout1 pending at 0x04", rdata_b, 1);
    check(irq_b == 1'b1, "R10 layout1 irq", {31'b0, irq_b}, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule